// File: doc/BRIEF.md
# Conflict-Checked Command Set Claimer

This block hands out command sets to active requests. A command set is a slot of several commands, each with an enable bit and a target address. A requester presents up to `MAX_REQ` target addresses. The block walks every set of the selected group that is already in use. For each one it compares every enabled command address against the request's addresses, one command per cycle. It refuses the request if any of them match. If nothing matches, it grants the lowest-numbered free set in the group and marks that set in use. If no set is free, it refuses the request. A refusal leaves all state untouched so the requester can retry. A release input returns a set to the free pool.

The group is given as an offset and a count. If the active group has no sets, the wake group is used for active traffic. A set taken from the wake group this way is "borrowed". Three things happen when a set is borrowed: its command enables are ordered cleared, its completion interrupt is enabled, and it is remembered as borrowed. When a borrowed set is released, the block orders the trigger and mode enable stopped and the command enables zeroed, and it drops the interrupt enable again. Programming the set's commands happens downstream of this block.

Top module: `cmdset_claimer`

## Requirements
- R1: After reset, `in_use_o`, `borrow_irq_o`, `cmd_zero_o` and `stop_trig_o` are all zero, `done_o` is low and `idle_o` is high.
- R2: A request is taken on a clock edge only while `idle_o` is high. A request raised while a scan runs is ignored. Each taken request yields exactly one `done_o` pulse, one cycle long.
- R3: The result is busy when some set in the selected group is in use and holds an enabled command whose address equals one of the first `req_cnt_i` request lanes. Lane k sits at `req_addr_i[k*ADDR_W +: ADDR_W]`. Lanes at index `req_cnt_i` and above are never compared.
- R4: Disabled commands never cause a conflict. Neither do commands of free sets.
- R5: With no conflict, the result is a grant of the lowest-numbered free set whose number lies in [offset, offset+count). `grant_id_o` carries the absolute set number. The set's `in_use_o` bit is already set in the `done_o` cycle.
- R6: The result is busy when the group has no free set, and also when the selected group count is zero.
- R7: A busy result leaves `in_use_o` and `borrow_irq_o` unchanged.
- R8: When `act_cnt_i` is zero at acceptance, the wake group is used. On a grant, `borrowed_o` is high and `borrow_irq_o` has the set's bit set. In the `done_o` cycle, `cmd_zero_o` pulses that set's bit.
- R9: A release of an in-use set clears its `in_use_o` bit on the next cycle and pulses its `cmd_zero_o` bit for one cycle. If the set was borrowed, `stop_trig_o` also pulses its bit and its `borrow_irq_o` bit clears.
- R10: A release of a set that is not in use changes nothing. No pulse follows.
- R11: A release and a result that land on the same clock edge both take effect.
- R12: When no conflict cuts the scan short, `done_o` is high in the cycle after the (count x `CMDS`)-th edge following acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | New active request |
| req_cnt_i | input | $clog2(MAX_REQ+1) | Number of valid request lanes |
| req_addr_i | input | MAX_REQ*ADDR_W | Request addresses, lane k at bits k*ADDR_W |
| act_off_i | input | $clog2(NUM_SETS) | First set of the active group |
| act_cnt_i | input | $clog2(NUM_SETS+1) | Sets in the active group |
| wake_off_i | input | $clog2(NUM_SETS) | First set of the wake group |
| wake_cnt_i | input | $clog2(NUM_SETS+1) | Sets in the wake group |
| cmd_en_i | input | NUM_SETS*CMDS | Command enable snapshot, bit s*CMDS+c |
| cmd_addr_i | input | NUM_SETS*CMDS*ADDR_W | Command addresses, entry s*CMDS+c |
| rel_valid_i | input | 1 | Release strobe |
| rel_id_i | input | $clog2(NUM_SETS) | Set to release |
| idle_o | output | 1 | Ready to accept a request |
| done_o | output | 1 | Result valid, one cycle |
| grant_o | output | 1 | Result is a grant |
| busy_o | output | 1 | Result is busy |
| grant_id_o | output | $clog2(NUM_SETS) | Granted set number |
| borrowed_o | output | 1 | Grant came from the wake group |
| in_use_o | output | NUM_SETS | In-use mark per set |
| borrow_irq_o | output | NUM_SETS | Interrupt enable of borrowed sets |
| cmd_zero_o | output | NUM_SETS | Pulse: zero this set's command enables |
| stop_trig_o | output | NUM_SETS | Pulse: clear trigger and mode enable |

## Verification
The two functions that can share a clock edge are a release and the registering of a scan result. The release frees a set outside the scanned group while the grant marks another. The bench places a release strobe exactly on the edge that ends a full-length wake-group scan, which it finds by counting cycles from acceptance. In that `done_o` cycle it expects both in-use bits updated and both `cmd_zero_o` bits pulsed. A request raised during a scan is also driven. It would have produced a different result, and the bench confirms that only the first request's result appears.

// File: rtl/claim_pkg.sv
package claim_pkg;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_BUSY = 1'b1
   } walk_st_e;

   // index width that never collapses to zero
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/claim_walk.sv
module claim_walk import claim_pkg::*; #(
   parameter  int NUM_SETS = 8,
   parameter  int CMDS     = 4,
   parameter  int ADDR_W   = 16,
   parameter  int MAX_REQ  = 4,
   localparam int SET_W    = idx_w(NUM_SETS),
   localparam int CMD_W    = idx_w(CMDS),
   localparam int CNT_W    = $clog2(NUM_SETS + 1),
   localparam int RCNT_W   = $clog2(MAX_REQ + 1),
   localparam int FLAT_W   = idx_w(NUM_SETS * CMDS)
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            start_i,
   input  logic [SET_W-1:0]                off_i,
   input  logic [CNT_W-1:0]                cnt_i,
   input  logic [RCNT_W-1:0]               rcnt_i,
   input  logic [MAX_REQ*ADDR_W-1:0]       raddr_i,
   input  logic [NUM_SETS-1:0]             in_use_i,
   input  logic [NUM_SETS*CMDS-1:0]        cmd_en_i,
   input  logic [NUM_SETS*CMDS*ADDR_W-1:0] cmd_addr_i,
   output logic                            idle_o,
   output logic                            fin_o,
   output logic                            hit_o
);

   walk_st_e            st_q;
   logic [CNT_W-1:0]    idx_q;
   logic [CMD_W-1:0]    cmd_q;
   logic [CNT_W:0]      set_sum;
   logic                in_range;
   logic [SET_W-1:0]    set_sel;
   logic [FLAT_W-1:0]   flat;
   logic [ADDR_W-1:0]   cur_addr;
   logic [MAX_REQ-1:0]  lane_hit;
   logic                last;

   assign set_sum  = (CNT_W+1)'(off_i) + (CNT_W+1)'(idx_q);
   assign in_range = set_sum < (CNT_W+1)'(NUM_SETS);
   assign set_sel  = SET_W'(set_sum);
   assign flat     = FLAT_W'(set_sel) * FLAT_W'(CMDS) + FLAT_W'(cmd_q);
   assign cur_addr = cmd_addr_i[flat*ADDR_W +: ADDR_W];

   // one comparator per request lane, lanes past the count stay silent
   for (genvar k = 0; k < MAX_REQ; k++) begin : g_lane
      assign lane_hit[k] = (RCNT_W'(k) < rcnt_i) &&
                           (raddr_i[k*ADDR_W +: ADDR_W] == cur_addr);
   end

   assign hit_o  = (st_q == WALK_BUSY) && (cnt_i != '0) && in_range &&
                   in_use_i[set_sel] && cmd_en_i[flat] && (|lane_hit);
   assign last   = (idx_q == cnt_i - CNT_W'(1)) && (cmd_q == CMD_W'(CMDS - 1));
   assign fin_o  = (st_q == WALK_BUSY) && ((cnt_i == '0) || hit_o || last);
   assign idle_o = (st_q == WALK_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= WALK_IDLE;
         idx_q <= '0;
         cmd_q <= '0;
      end else begin
         case (st_q)
            WALK_IDLE: begin
               if (start_i) begin
                  st_q  <= WALK_BUSY;
                  idx_q <= '0;
                  cmd_q <= '0;
               end
            end
            default: begin
               if (fin_o) begin
                  st_q <= WALK_IDLE;
               end else if (cmd_q == CMD_W'(CMDS - 1)) begin
                  cmd_q <= '0;
                  idx_q <= idx_q + CNT_W'(1);
               end else begin
                  cmd_q <= cmd_q + CMD_W'(1);
               end
            end
         endcase
      end
   end

   // walk never leaves the selected group (R3)
   p_walk_in_group_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == WALK_BUSY && cnt_i != '0) |-> (idx_q < cnt_i));

   // a start is only issued to an idle walker (R2)
   p_walk_start_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |-> (st_q == WALK_IDLE));

endmodule

// File: rtl/claim_pick.sv
module claim_pick import claim_pkg::*; #(
   parameter  int NUM_SETS = 8,
   localparam int SET_W    = idx_w(NUM_SETS),
   localparam int CNT_W    = $clog2(NUM_SETS + 1)
) (
   input  logic [NUM_SETS-1:0] in_use_i,
   input  logic [SET_W-1:0]    off_i,
   input  logic [CNT_W-1:0]    cnt_i,
   output logic                found_o,
   output logic [SET_W-1:0]    id_o
);

   logic [NUM_SETS-1:0] cand;
   logic [CNT_W:0]      lo;
   logic [CNT_W:0]      hi;

   assign lo = (CNT_W+1)'(off_i);
   assign hi = lo + (CNT_W+1)'(cnt_i);

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_cand
      assign cand[s] = !in_use_i[s] &&
                       ((CNT_W+1)'(s) >= lo) && ((CNT_W+1)'(s) < hi);
   end

   // lowest index wins: scan downward so the last write is the smallest
   always_comb begin
      id_o = '0;
      for (int s = NUM_SETS - 1; s >= 0; s--) begin
         if (cand[s]) id_o = SET_W'(s);
      end
   end

   assign found_o = |cand;

endmodule

// File: rtl/claim_track.sv
module claim_track import claim_pkg::*; #(
   parameter  int NUM_SETS = 8,
   localparam int SET_W    = idx_w(NUM_SETS)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                grant_i,
   input  logic [SET_W-1:0]    grant_id_i,
   input  logic                borrow_i,
   input  logic                rel_i,
   input  logic [SET_W-1:0]    rel_id_i,
   output logic [NUM_SETS-1:0] in_use_o,
   output logic [NUM_SETS-1:0] irq_o,
   output logic [NUM_SETS-1:0] zero_o,
   output logic [NUM_SETS-1:0] stop_o
);

   logic [NUM_SETS-1:0] use_q, use_d;
   logic [NUM_SETS-1:0] irq_q, irq_d;
   logic [NUM_SETS-1:0] zero_q, zero_d;
   logic [NUM_SETS-1:0] stop_q, stop_d;
   logic [NUM_SETS-1:0] g_hot, r_hot;
   logic                rel_fire;

   assign g_hot    = NUM_SETS'(1) << grant_id_i;
   assign r_hot    = NUM_SETS'(1) << rel_id_i;
   assign rel_fire = rel_i && use_q[rel_id_i];

   always_comb begin
      use_d  = use_q;
      irq_d  = irq_q;
      zero_d = '0;
      stop_d = '0;
      if (grant_i) begin
         use_d = use_d | g_hot;
         if (borrow_i) begin
            irq_d  = irq_d | g_hot;
            zero_d = zero_d | g_hot;
         end
      end
      if (rel_fire) begin
         use_d  = use_d & ~r_hot;
         zero_d = zero_d | r_hot;
         if (irq_q[rel_id_i]) begin
            irq_d  = irq_d & ~r_hot;
            stop_d = r_hot;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         use_q  <= '0;
         irq_q  <= '0;
         zero_q <= '0;
         stop_q <= '0;
      end else begin
         use_q  <= use_d;
         irq_q  <= irq_d;
         zero_q <= zero_d;
         stop_q <= stop_d;
      end
   end

   assign in_use_o = use_q;
   assign irq_o    = irq_q;
   assign zero_o   = zero_q;
   assign stop_o   = stop_q;

   p_grant_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_i |-> !use_q[grant_id_i]);

   p_rel_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rel_fire |=> !use_q[$past(rel_id_i)]);

   p_rel_idle_noop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_i && !use_q[rel_id_i] && !grant_i) |=> (use_q == $past(use_q)) && (zero_q == '0));

   p_same_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_i && rel_fire) |=> use_q[$past(grant_id_i)] && !use_q[$past(rel_id_i)]);

   p_irq_in_use_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q & ~use_q) == '0);

   p_stop_with_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(stop_q) && ((stop_q & ~zero_q) == '0));

endmodule

// File: rtl/cmdset_claimer.sv
module cmdset_claimer import claim_pkg::*; #(
   parameter  int NUM_SETS = 8,
   parameter  int CMDS     = 4,
   parameter  int ADDR_W   = 16,
   parameter  int MAX_REQ  = 4,
   localparam int SET_W    = idx_w(NUM_SETS),
   localparam int CNT_W    = $clog2(NUM_SETS + 1),
   localparam int RCNT_W   = $clog2(MAX_REQ + 1)
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            req_valid_i,
   input  logic [RCNT_W-1:0]               req_cnt_i,
   input  logic [MAX_REQ*ADDR_W-1:0]       req_addr_i,
   input  logic [SET_W-1:0]                act_off_i,
   input  logic [CNT_W-1:0]                act_cnt_i,
   input  logic [SET_W-1:0]                wake_off_i,
   input  logic [CNT_W-1:0]                wake_cnt_i,
   input  logic [NUM_SETS*CMDS-1:0]        cmd_en_i,
   input  logic [NUM_SETS*CMDS*ADDR_W-1:0] cmd_addr_i,
   input  logic                            rel_valid_i,
   input  logic [SET_W-1:0]                rel_id_i,
   output logic                            idle_o,
   output logic                            done_o,
   output logic                            grant_o,
   output logic                            busy_o,
   output logic [SET_W-1:0]                grant_id_o,
   output logic                            borrowed_o,
   output logic [NUM_SETS-1:0]             in_use_o,
   output logic [NUM_SETS-1:0]             borrow_irq_o,
   output logic [NUM_SETS-1:0]             cmd_zero_o,
   output logic [NUM_SETS-1:0]             stop_trig_o
);

   if (NUM_SETS < 2) begin : g_bad_sets
      $error("cmdset_claimer: NUM_SETS must be at least 2");
   end
   if (CMDS < 1 || MAX_REQ < 1 || ADDR_W < 1) begin : g_bad_dims
      $error("cmdset_claimer: CMDS, MAX_REQ and ADDR_W must be positive");
   end

   logic                      walk_idle, walk_fin, walk_hit;
   logic                      accept;
   logic                      pick_found;
   logic [SET_W-1:0]          pick_id;
   logic                      grant_now;
   logic [SET_W-1:0]          g_off_q;
   logic [CNT_W-1:0]          g_cnt_q;
   logic                      g_wake_q;
   logic [RCNT_W-1:0]         r_cnt_q;
   logic [MAX_REQ*ADDR_W-1:0] r_addr_q;
   logic                      done_q, grant_q, busy_q, brw_q;
   logic [SET_W-1:0]          id_q;
   logic                      rel_hit;

   assign accept    = req_valid_i && walk_idle;
   assign grant_now = walk_fin && !walk_hit && pick_found;
   assign rel_hit   = rel_valid_i && in_use_o[rel_id_i];

   // latch the request and the group it targets
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         g_off_q  <= '0;
         g_cnt_q  <= '0;
         g_wake_q <= 1'b0;
         r_cnt_q  <= '0;
         r_addr_q <= '0;
      end else if (accept) begin
         g_wake_q <= (act_cnt_i == '0);
         g_off_q  <= (act_cnt_i == '0) ? wake_off_i : act_off_i;
         g_cnt_q  <= (act_cnt_i == '0) ? wake_cnt_i : act_cnt_i;
         r_cnt_q  <= req_cnt_i;
         r_addr_q <= req_addr_i;
      end
   end

   claim_walk #(
      .NUM_SETS (NUM_SETS),
      .CMDS     (CMDS),
      .ADDR_W   (ADDR_W),
      .MAX_REQ  (MAX_REQ)
   ) i_walk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (accept),
      .off_i      (g_off_q),
      .cnt_i      (g_cnt_q),
      .rcnt_i     (r_cnt_q),
      .raddr_i    (r_addr_q),
      .in_use_i   (in_use_o),
      .cmd_en_i   (cmd_en_i),
      .cmd_addr_i (cmd_addr_i),
      .idle_o     (walk_idle),
      .fin_o      (walk_fin),
      .hit_o      (walk_hit)
   );

   claim_pick #(
      .NUM_SETS (NUM_SETS)
   ) i_pick (
      .in_use_i (in_use_o),
      .off_i    (g_off_q),
      .cnt_i    (g_cnt_q),
      .found_o  (pick_found),
      .id_o     (pick_id)
   );

   claim_track #(
      .NUM_SETS (NUM_SETS)
   ) i_track (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .grant_i    (grant_now),
      .grant_id_i (pick_id),
      .borrow_i   (g_wake_q),
      .rel_i      (rel_valid_i),
      .rel_id_i   (rel_id_i),
      .in_use_o   (in_use_o),
      .irq_o      (borrow_irq_o),
      .zero_o     (cmd_zero_o),
      .stop_o     (stop_trig_o)
   );

   // result register, aligned with the in-use update
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_q  <= 1'b0;
         grant_q <= 1'b0;
         busy_q  <= 1'b0;
         brw_q   <= 1'b0;
         id_q    <= '0;
      end else begin
         done_q  <= walk_fin;
         grant_q <= grant_now;
         busy_q  <= walk_fin && !grant_now;
         brw_q   <= grant_now && g_wake_q;
         if (grant_now) id_q <= pick_id;
      end
   end

   assign idle_o     = walk_idle;
   assign done_o     = done_q;
   assign grant_o    = grant_q;
   assign busy_o     = busy_q;
   assign borrowed_o = brw_q;
   assign grant_id_o = id_q;

   p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_result_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (grant_o ^ busy_o));

   p_result_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> (!grant_o && !busy_o && !borrowed_o));

   p_grant_marks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && grant_o) |-> in_use_o[grant_id_o]);

   p_group_fits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |-> ((act_cnt_i == '0)
                  ? ((CNT_W+1)'(wake_off_i) + (CNT_W+1)'(wake_cnt_i) <= (CNT_W+1)'(NUM_SETS))
                  : ((CNT_W+1)'(act_off_i)  + (CNT_W+1)'(act_cnt_i)  <= (CNT_W+1)'(NUM_SETS))));

   p_busy_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && busy_o && !$past(rel_hit)) |-> (in_use_o == $past(in_use_o)));

   p_borrow_marks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && grant_o && borrowed_o) |->
         (borrow_irq_o[grant_id_o] && cmd_zero_o[grant_id_o]));

endmodule

// File: tb/test_cmdset_claimer.sv
module test_cmdset_claimer;

   localparam int NS = 8;
   localparam int NC = 4;
   localparam int AW = 16;
   localparam int MR = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [2:0]      req_cnt = '0;
   logic [MR*AW-1:0] req_addr = '0;
   logic [2:0]      act_off = 3'd2;
   logic [3:0]      act_cnt = 4'd3;
   logic [2:0]      wake_off = 3'd5;
   logic [3:0]      wake_cnt = 4'd3;
   logic [NS*NC-1:0]    cmd_en;
   logic [NS*NC*AW-1:0] cmd_addr;
   logic            rel_valid = 1'b0;
   logic [2:0]      rel_id = '0;
   logic            idle_o, done_o, grant_o, busy_o, borrowed_o;
   logic [2:0]      grant_id_o;
   logic [NS-1:0]   in_use_o, borrow_irq_o, cmd_zero_o, stop_trig_o;

   logic [AW-1:0] b_addr [NS][NC];
   logic          b_en   [NS][NC];

   always #2 clk = ~clk;

   always_comb begin
      for (int s = 0; s < NS; s++) begin
         for (int c = 0; c < NC; c++) begin
            cmd_en[s*NC+c]             = b_en[s][c];
            cmd_addr[(s*NC+c)*AW +: AW] = b_addr[s][c];
         end
      end
   end

   cmdset_claimer #(.NUM_SETS(NS), .CMDS(NC), .ADDR_W(AW), .MAX_REQ(MR)) i_cmdset_claimer (
      .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cnt_i(req_cnt),
      .req_addr_i(req_addr), .act_off_i(act_off), .act_cnt_i(act_cnt),
      .wake_off_i(wake_off), .wake_cnt_i(wake_cnt), .cmd_en_i(cmd_en),
      .cmd_addr_i(cmd_addr), .rel_valid_i(rel_valid), .rel_id_i(rel_id),
      .idle_o(idle_o), .done_o(done_o), .grant_o(grant_o), .busy_o(busy_o),
      .grant_id_o(grant_id_o), .borrowed_o(borrowed_o), .in_use_o(in_use_o),
      .borrow_irq_o(borrow_irq_o), .cmd_zero_o(cmd_zero_o), .stop_trig_o(stop_trig_o));

   typedef struct {
      bit          g;
      int          id;
      bit          b;
      logic [NS-1:0] use_v;
      logic [NS-1:0] irq_v;
      logic [NS-1:0] zero_v;
      string       tag;
   } item_t;

   item_t         sbq [$];
   item_t         mon_it;
   int            n_chk = 0;
   int            n_bad = 0;
   logic [NS-1:0] m_use = '0;
   logic [NS-1:0] m_irq = '0;
   int            cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R2", "result without accepted request", 1, 0);
         end else begin
            mon_it = sbq.pop_front();
            chk(grant_o == mon_it.g, mon_it.tag, "grant_o", grant_o, mon_it.g);
            chk(busy_o == !mon_it.g, mon_it.tag, "busy_o", busy_o, !mon_it.g);
            if (mon_it.g)
               chk(int'(grant_id_o) == mon_it.id, mon_it.tag, "grant_id_o", grant_id_o, mon_it.id);
            chk(borrowed_o == mon_it.b, mon_it.tag, "borrowed_o", borrowed_o, mon_it.b);
            chk(in_use_o == mon_it.use_v, mon_it.tag, "in_use_o", in_use_o, mon_it.use_v);
            chk(borrow_irq_o == mon_it.irq_v, mon_it.tag, "borrow_irq_o", borrow_irq_o, mon_it.irq_v);
            chk(cmd_zero_o == mon_it.zero_v, mon_it.tag, "cmd_zero_o", cmd_zero_o, mon_it.zero_v);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   // driver: model expectation, push, drive, wait for the result
   task automatic send(input int rc, input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                       input logic [AW-1:0] a2, input logic [AW-1:0] a3, input string tag,
                       input int rel_at, input int rel_sel, input int intr_at, input int exp_lat);
      logic [AW-1:0] la [MR];
      item_t it;
      bit wk, hit, seen;
      int off, cnt, n;
      logic [NS-1:0] eu, ei;
      la[0] = a0; la[1] = a1; la[2] = a2; la[3] = a3;
      wk  = (act_cnt == 0);
      off = wk ? int'(wake_off) : int'(act_off);
      cnt = wk ? int'(wake_cnt) : int'(act_cnt);
      hit = 1'b0;
      for (int i = 0; i < cnt; i++)
         if (m_use[off+i])
            for (int c = 0; c < NC; c++)
               if (b_en[off+i][c])
                  for (int k = 0; k < rc; k++)
                     if (la[k] == b_addr[off+i][c]) hit = 1'b1;
      it.g = 1'b0; it.id = 0; it.zero_v = '0; it.tag = tag;
      if (!hit)
         for (int i = cnt - 1; i >= 0; i--)
            if (!m_use[off+i]) begin it.g = 1'b1; it.id = off + i; end
      it.b = it.g && wk;
      eu = m_use; ei = m_irq;
      if (it.g) begin
         eu[it.id] = 1'b1;
         if (wk) begin ei[it.id] = 1'b1; it.zero_v[it.id] = 1'b1; end
      end
      if (rel_at >= 0 && m_use[rel_sel]) begin
         eu[rel_sel] = 1'b0; ei[rel_sel] = 1'b0; it.zero_v[rel_sel] = 1'b1;
      end
      it.use_v = eu; it.irq_v = ei;
      sbq.push_back(it);
      m_use = eu; m_irq = ei;

      @(negedge clk);
      while (!idle_o) @(negedge clk);
      req_cnt   = 3'(rc);
      req_addr  = {a3, a2, a1, a0};
      req_valid = 1'b1;
      n = 0; seen = 1'b0;
      while (!seen && n < 400) begin
         @(negedge clk);
         n++;
         if (n == 1) req_valid = 1'b0;
         if (intr_at > 0 && n == intr_at) begin
            req_valid = 1'b1; req_cnt = 3'd1; req_addr = {4{16'h1060}};
         end
         if (intr_at > 0 && n == intr_at + 1) req_valid = 1'b0;
         if (rel_at >= 0 && n == rel_at) begin rel_valid = 1'b1; rel_id = 3'(rel_sel); end
         if (rel_at >= 0 && n == rel_at + 1) rel_valid = 1'b0;
         if (done_o) seen = 1'b1;
      end
      req_valid = 1'b0;
      rel_valid = 1'b0;
      if (!seen) chk(1'b0, tag, "no result (timeout)", n, 0);
      if (exp_lat >= 0) chk(n == exp_lat, "R12", "result latency", n, exp_lat);
      repeat (3) @(negedge clk);
   endtask

   task automatic release_set(input int id, input string tag);
      bit fire;
      logic [NS-1:0] ez, es;
      fire = m_use[id];
      ez = '0; es = '0;
      if (fire) begin
         ez[id] = 1'b1;
         if (m_irq[id]) es[id] = 1'b1;
         m_use[id] = 1'b0;
         m_irq[id] = 1'b0;
      end
      @(negedge clk);
      rel_valid = 1'b1; rel_id = 3'(id);
      @(negedge clk);
      rel_valid = 1'b0;
      chk(in_use_o == m_use, tag, "in_use_o after release", in_use_o, m_use);
      chk(cmd_zero_o == ez, tag, "cmd_zero_o after release", cmd_zero_o, ez);
      chk(stop_trig_o == es, tag, "stop_trig_o after release", stop_trig_o, es);
      chk(borrow_irq_o == m_irq, tag, "borrow_irq_o after release", borrow_irq_o, m_irq);
      @(negedge clk);
      chk(cmd_zero_o == '0 && stop_trig_o == '0, tag, "pulses one cycle", {cmd_zero_o, stop_trig_o}, 0);
   endtask

   initial begin
      for (int s = 0; s < NS; s++)
         for (int c = 0; c < NC; c++) begin
            b_addr[s][c] = 16'h1000 + 16'(s*16 + c);
            b_en[s][c]   = 1'b1;
         end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(in_use_o == '0 && borrow_irq_o == '0, "R1", "state after reset", {in_use_o, borrow_irq_o}, 0);
      chk(cmd_zero_o == '0 && stop_trig_o == '0, "R1", "pulses after reset", {cmd_zero_o, stop_trig_o}, 0);
      chk(idle_o && !done_o, "R1", "idle/done after reset", {idle_o, done_o}, 2);

      // R5/R12: empty active group, full-length scan, lowest free set 2
      send(1, 16'hAAAA, 16'h0, 16'h0, 16'h0, "R5", -1, 0, 0, 13);
      // R3/R7: address of set 2 command 0 collides
      send(1, 16'h1020, 16'h0, 16'h0, 16'h0, "R3/R7", -1, 0, 0, -1);
      // R3 lane limit: colliding address sits in lane 1, count is 1
      send(1, 16'h7777, 16'h1021, 16'h0, 16'h0, "R3", -1, 0, 0, -1);
      // R3 second lane, last command of set 2
      send(2, 16'h5555, 16'h1023, 16'h0, 16'h0, "R3", -1, 0, 0, -1);
      // R4: disabled command no longer collides
      b_en[2][3] = 1'b0;
      send(1, 16'h1023, 16'h0, 16'h0, 16'h0, "R4", -1, 0, 0, -1);
      // R6/R7: group full
      send(1, 16'h9999, 16'h0, 16'h0, 16'h0, "R6/R7", -1, 0, 0, -1);
      // R9 plain release, R10 repeated release
      release_set(3, "R9");
      release_set(3, "R10");
      // R4: address of a free set does not collide
      send(1, 16'h1031, 16'h0, 16'h0, 16'h0, "R4", -1, 0, 0, -1);
      // R8: no active sets, wake set borrowed
      act_cnt = 4'd0;
      send(1, 16'h1020, 16'h0, 16'h0, 16'h0, "R8", -1, 0, 0, -1);
      // R3 on the wake group
      send(1, 16'h1050, 16'h0, 16'h0, 16'h0, "R3", -1, 0, 0, -1);
      // R11/R12: release of set 2 on the result edge of a 12-cycle scan
      send(1, 16'hCCCC, 16'h0, 16'h0, 16'h0, "R11", 12, 2, 0, 13);
      // R9 borrowed release
      release_set(5, "R9");
      // R2: a second request during the scan is ignored
      send(1, 16'hDDDD, 16'h0, 16'h0, 16'h0, "R2/R8", -1, 0, 2, -1);
      // R6: selected group of zero sets
      wake_cnt = 4'd0;
      send(1, 16'hEEEE, 16'h0, 16'h0, 16'h0, "R6", -1, 0, 0, 2);

      repeat (5) @(negedge clk);
      chk(sbq.size() == 0, "R2", "results outstanding", sbq.size(), 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule